// File: doc/BRIEF.md
# Floating-Point Status Condition and Sticky Exception Updater

This block keeps the status word of a floating-point unit current after each arithmetic result. Once the datapath has produced a result, it presents three things to the block: the result's sign, a class code, and the exception bits the operation raised. It also raises a one-cycle update strobe. On the next clock edge the block does four things:

- It rebuilds the four condition flags from the sign and class.
- It replaces the exception byte with the new exception bits.
- It ORs a summary of those exceptions into a sticky accrued byte.
- It raises a trap request when any exception is enabled in the trap-enable byte.

Comparisons and tests still update the flags, but they must not store their result. A suppress input marks these operations. The block then holds back its result-write enable for that update while it updates the status in full.

Top module: `fp_status_update`

## Requirements
- R1: After reset, `status` is all zero, and `trap` and `result_we` are low.
- R2: Every update first clears the four condition flags: N at bit 27, Z at bit 26, I at bit 25 and NAN at bit 24. The update then sets N exactly when `res_sign` is 1, whatever the class.
- R3: Class codes are 0 = finite number, 1 = zero, 2 = infinity, 3 = quiet NaN and 4 = signalling NaN; codes 5 to 7 are treated as finite. Zero sets Z and infinity sets I. Either NaN sets NAN, and a signalling NaN also forces the SNAN exception bit. A finite number sets none of Z, I or NAN.
- R4: Each update loads the exception byte (`status[15:8]`) with `exc_in`, with bit 6 also forced by a signalling NaN. Within this byte, bit 7 = BSUN, 6 = SNAN, 5 = OPERR, 4 = OVFL, 3 = UNFL, 2 = DZ, 1 = INEX2 and 0 = INEX1.
- R5: Accrued invalid-operation (`status[7]`) is set when BSUN, SNAN or OPERR is set in the new exception byte.
- R6: Accrued overflow (`status[6]`) is set from OVFL, and accrued divide-by-zero (`status[4]`) is set from DZ.
- R7: Accrued underflow (`status[5]`) is set only when UNFL and INEX2 are both set. UNFL alone leaves it unchanged.
- R8: Accrued inexact (`status[3]`) is set when INEX1, INEX2 or OVFL is set.
- R9: Accrued bits are never cleared by an update. Bits 31:28, 23:16 and 2:0 keep their value.
- R10: `trap` is high for exactly the one cycle in which the new status appears. It is high when the new exception byte ANDed with `trap_en` is nonzero.
- R11: When `no_wb` is high with the strobe, `result_we` stays low and the status still updates. Without `no_wb`, `result_we` pulses for that one cycle.
- R12: Without `upd_valid`, `status` holds its value, and `trap` and `result_we` stay low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Result update strobe |
| res_sign | input | 1 | Sign of the result |
| res_class | input | 3 | Result class code |
| exc_in | input | 8 | Exception bits raised by the operation |
| no_wb | input | 1 | Suppress result write (compare/test) |
| trap_en | input | 8 | Trap-enable byte, same layout as the exception byte |
| status | output | 32 | Status word |
| trap | output | 1 | Trap request pulse |
| result_we | output | 1 | Result write enable pulse |

## Verification
The accrued byte only ever grows, so once one scenario has set a bit, no later stimulus can show that another condition leaves it alone. This makes the underflow-needs-inexact rule hard to reach. The bench therefore resets the block before each scenario that tests a single accrual rule. It then applies UNFL alone and checks that accrued underflow stays clear. After that it adds INEX2 and checks that the bit sets. Separate updates with different sets of exceptions, followed by an update that raises none, show that the bits are sticky.

// File: rtl/fp_status_update.sv
module fp_status_update #(
  parameter int CLS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic             res_sign,
  input  logic [CLS_W-1:0] res_class,
  input  logic [7:0]       exc_in,
  input  logic             no_wb,
  input  logic [7:0]       trap_en,
  output logic [31:0]      status,
  output logic             trap,
  output logic             result_we
);

  localparam logic [CLS_W-1:0] C_ZERO = CLS_W'(1);
  localparam logic [CLS_W-1:0] C_INF  = CLS_W'(2);
  localparam logic [CLS_W-1:0] C_QNAN = CLS_W'(3);
  localparam logic [CLS_W-1:0] C_SNAN = CLS_W'(4);

  localparam int E_BSUN = 7, E_SNAN = 6, E_OPERR = 5, E_OVFL = 4;
  localparam int E_UNFL = 3, E_DZ = 2, E_INEX2 = 1, E_INEX1 = 0;

  logic       is_snan;
  logic [3:0] cc_new;
  logic [7:0] exc_new;
  logic [4:0] acc_new;

  assign is_snan = (res_class == C_SNAN);

  assign cc_new = {res_sign,
                   res_class == C_ZERO,
                   res_class == C_INF,
                   (res_class == C_QNAN) || is_snan};

  assign exc_new = exc_in | (8'(is_snan) << E_SNAN);

  assign acc_new = {exc_new[E_BSUN] | exc_new[E_SNAN] | exc_new[E_OPERR],
                    exc_new[E_OVFL],
                    exc_new[E_UNFL] & exc_new[E_INEX2],
                    exc_new[E_DZ],
                    exc_new[E_INEX1] | exc_new[E_INEX2] | exc_new[E_OVFL]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status    <= '0;
      trap      <= 1'b0;
      result_we <= 1'b0;
    end else begin
      trap      <= upd_valid && |(exc_new & trap_en);
      result_we <= upd_valid && !no_wb;
      if (upd_valid)
        status <= {status[31:28], cc_new, status[23:16], exc_new,
                   status[7:3] | acc_new, status[2:0]};
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (status == 32'd0 && !trap && !result_we)); // R1

  AST_ACCR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status[7:3] & $past(status[7:3])) == $past(status[7:3]))); // R9

  AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status[26:24])); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ($stable(status) && !trap && !result_we)); // R12

  AST_TRAP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $past(upd_valid)); // R10

  AST_UNFL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && exc_in[E_UNFL] && exc_in[E_INEX2]) |=> status[5]); // R7

  AST_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && no_wb) |=> !result_we); // R11

endmodule

// File: tb/fp_status_update_test.sv
module fp_status_update_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_valid = 1'b0;
  logic res_sign = 1'b0;
  logic [2:0] res_class = 3'd0;
  logic [7:0] exc_in = 8'd0;
  logic no_wb = 1'b0;
  logic [7:0] trap_en = 8'd0;
  logic [31:0] status;
  logic trap, result_we;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_st = 32'd0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_status_update uut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .res_sign(res_sign),
    .res_class(res_class), .exc_in(exc_in), .no_wb(no_wb), .trap_en(trap_en),
    .status(status), .trap(trap), .result_we(result_we)
  );

  function automatic logic [31:0] model(input logic [31:0] old, input logic s,
                                        input logic [2:0] c, input logic [7:0] x);
    logic [31:0] n;
    logic [7:0] e;
    n = old;
    n[27:24] = 4'b0;
    n[27] = s;
    e = x;
    case (c)
      3'd1: n[26] = 1'b1;
      3'd2: n[25] = 1'b1;
      3'd3: n[24] = 1'b1;
      3'd4: begin n[24] = 1'b1; e[6] = 1'b1; end
      default: ;
    endcase
    n[15:8] = e;
    if (e[7] | e[6] | e[5]) n[7] = 1'b1;
    if (e[4]) n[6] = 1'b1;
    if (e[3] & e[1]) n[5] = 1'b1;
    if (e[2]) n[4] = 1'b1;
    if (e[0] | e[1] | e[4]) n[3] = 1'b1;
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] es,
                       input logic et, input logic ew);
    checks++;
    if (status !== es || trap !== et || result_we !== ew) begin
      errors++;
      $display("FAIL %s: status=%h trap=%b we=%b expected status=%h trap=%b we=%b",
               req, status, trap, result_we, es, et, ew);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    upd_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_st = 32'd0;
  endtask

  task automatic apply(input string req, input logic s, input logic [2:0] c,
                       input logic [7:0] x, input logic [7:0] en, input logic nw);
    logic [7:0] e;
    @(negedge clk);
    res_sign = s; res_class = c; exc_in = x; trap_en = en; no_wb = nw;
    upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
    e = x | ((c == 3'd4) ? 8'h40 : 8'h00);
    exp_st = model(exp_st, s, c, x);
    check(req, exp_st, |(e & en), !nw);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", 32'd0, 1'b0, 1'b0);
  endtask

  task automatic t_classes();
    do_reset();
    apply("R3 zero", 1'b0, 3'd1, 8'h00, 8'h00, 1'b0);
    apply("R2 neg inf", 1'b1, 3'd2, 8'h00, 8'h00, 1'b0);
    apply("R3 qnan", 1'b0, 3'd3, 8'h00, 8'h00, 1'b0);
    apply("R3 snan", 1'b1, 3'd4, 8'h00, 8'h00, 1'b0);
    apply("R2 finite clears", 1'b0, 3'd0, 8'h00, 8'h00, 1'b0);
    apply("R3 code7 finite", 1'b1, 3'd7, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_iop();
    do_reset();
    apply("R5 operr", 1'b0, 3'd0, 8'h20, 8'h00, 1'b0);
    do_reset();
    apply("R5 bsun", 1'b0, 3'd0, 8'h80, 8'h00, 1'b0);
    do_reset();
    apply("R5 snan class", 1'b0, 3'd4, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_ovfl_dz();
    do_reset();
    apply("R6 R8 ovfl", 1'b0, 3'd2, 8'h10, 8'h00, 1'b0);
    do_reset();
    apply("R6 dz", 1'b1, 3'd2, 8'h04, 8'h00, 1'b0);
  endtask

  task automatic t_unfl();
    do_reset();
    apply("R7 unfl alone", 1'b0, 3'd0, 8'h08, 8'h00, 1'b0);
    checks++;
    if (status[5] !== 1'b0) begin
      errors++;
      $display("FAIL R7: accrued unfl=%b expected 0", status[5]);
    end
    apply("R7 unfl+inex2", 1'b0, 3'd0, 8'h0A, 8'h00, 1'b0);
  endtask

  task automatic t_inex();
    do_reset();
    apply("R8 inex1", 1'b0, 3'd0, 8'h01, 8'h00, 1'b0);
    do_reset();
    apply("R4 R8 inex2", 1'b0, 3'd0, 8'h02, 8'h00, 1'b0);
  endtask

  task automatic t_sticky();
    do_reset();
    apply("R9 set all", 1'b0, 3'd0, 8'hFF, 8'h00, 1'b0);
    apply("R9 R4 none", 1'b0, 3'd1, 8'h00, 8'h00, 1'b0);
    checks++;
    if (status[7:3] !== 5'b11111 || status[15:8] !== 8'h00) begin
      errors++;
      $display("FAIL R9: accrued=%b exc=%h expected 11111 00", status[7:3], status[15:8]);
    end
  endtask

  task automatic t_trap();
    do_reset();
    apply("R10 enabled", 1'b0, 3'd0, 8'h04, 8'h04, 1'b0);
    @(negedge clk);
    check("R10 one cycle", exp_st, 1'b0, 1'b0);
    apply("R10 masked", 1'b0, 3'd0, 8'h04, 8'hFB, 1'b0);
    apply("R10 snan enable", 1'b0, 3'd4, 8'h00, 8'h40, 1'b0);
  endtask

  task automatic t_nowb();
    do_reset();
    apply("R11 compare", 1'b1, 3'd0, 8'h02, 8'h00, 1'b1);
  endtask

  task automatic t_idle();
    do_reset();
    apply("R12 setup", 1'b1, 3'd1, 8'h10, 8'h00, 1'b0);
    @(negedge clk);
    res_sign = 1'b0; res_class = 3'd3; exc_in = 8'hFF; trap_en = 8'hFF; no_wb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R12 idle", exp_st, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_classes();
    t_iop();
    t_ovfl_dz();
    t_unfl();
    t_inex();
    t_sticky();
    t_trap();
    t_nowb();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule